// File: doc/BRIEF.md
# SDRAM Command Bus Timing Checker

This block watches the control pins of an SDRAM interface and judges every command that reaches the memory. It has no outputs toward the memory. It sits beside a memory controller, or in a test harness. On each rising clock edge it decodes the command from the clock-enable, select, strobe and write-enable pins, the bank select and the auto-precharge address bit. It keeps a model of four banks and counts the clocks since the last relevant event, both for each bank and for the whole bus.

A command that breaks a legality rule or a spacing rule raises a one-clock report with a numeric violation code. It also sets a flag that stays set until reset and adds one to a saturating violation counter. All minimum spacings are parameters given in clocks. The burst length is used to find the end of an auto-precharge burst. It starts from a parameter and can be reloaded from the low three address bits of a mode-register write.

A command that is flagged is treated as if it never reached the memory. Bank state and timers stay as they were.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: The pins {ras_n, cas_n, we_n} encode the commands as follows: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no-op. A cycle with cs_n high is a no-op whatever the strobes carry. A no-op never raises a violation and changes no state.
- R2: When cke was low at the previous rising edge, the command at the current edge is ignored. It raises nothing and changes no state.
- R3: The bank address selects bank 0 through bank 3 as ba = 00, 01, 10, 11. A read is judged against the state of the bank that ba selects only.
- R4: A mode set or a refresh issued while any bank is open raises code 2.
- R5: Any command other than a no-op issued fewer than T_MRD clocks after an accepted mode set raises code 1.
- R6: An activate to a bank that is already open raises code 3. A read or write to a bank that is closed raises code 6.
- R7: A read or write fewer than T_RCD clocks after that bank's activate raises code 8.
- R8: An activate fewer than T_RP clocks after the bank was precharged raises code 4. The bank counts as precharged either by an explicit precharge or at the end of an auto-precharge burst.
- R9: A precharge that would close an open bank fewer than T_RAS clocks after its activate raises code 9. With ap_flag high the precharge targets every open bank and ba is ignored.
- R10: An activate fewer than T_RRD clocks after an activate to a different bank raises code 5.
- R11: A read or write with ap_flag high locks its bank for the burst length. A read or write to that bank during the following burst-length-minus-one clocks raises code 7. The bank closes burst-length clocks after the command.
- R12: An accepted mode set reloads the burst length from mode_key: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives PAGE_LEN. Any other value keeps the current length.
- R13: Read and write commands may follow each other on consecutive clocks without a violation.
- R14: Each report appears on err_valid and err_code in the clock after the edge that sampled the command. err_code is 0 when no violation is reported. When several rules are broken at once, the lowest code is reported. err_flag stays set until reset. err_count adds one per violating command and saturates. A flagged command changes no bank state or timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| ap_flag | input | 1 | Auto-precharge / precharge-all address bit |
| mode_key | input | 3 | Burst-length field of the mode-set address |
| err_flag | output | 1 | Sticky: any violation since reset |
| err_valid | output | 1 | One-clock violation report |
| err_code | output | 4 | Code of the reported violation, 0 when none |
| err_count | output | COUNT_W | Saturating count of violating commands |

## Verification
Every result of the block appears on the report outputs exactly one clock after the rising edge that sampled the command, because a single register stage sits between the decision logic and the ports. The bench applies one command per clock at the falling edge. At the rising edge that samples the command, its behavioural model updates an integer timeline of bank events. It compares the report outputs at the next falling edge, so the comparison lands in the cycle the report is due and does not depend on the order of processes at the edge. Timing windows are judged from absolute cycle numbers in the model, so each spacing boundary is probed one clock short of its limit and again at the limit.

// File: rtl/sdr_mon_pkg.sv
// Shared types for the SDRAM command bus checker.
// Assumes: command set of a single-data-rate SDRAM with active-low strobes.
package sdr_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MRS,
        CMD_REF,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_BST
    } sdr_cmd_e;

    // Lower value = higher reporting priority.
    typedef enum logic [3:0] {
        ERR_NONE       = 4'd0,
        ERR_MRS_LOCK   = 4'd1,
        ERR_BANKS_OPEN = 4'd2,
        ERR_ACT_OPEN   = 4'd3,
        ERR_T_RP       = 4'd4,
        ERR_T_RRD      = 4'd5,
        ERR_RW_IDLE    = 4'd6,
        ERR_AP_LOCK    = 4'd7,
        ERR_T_RCD      = 4'd8,
        ERR_T_RAS      = 4'd9
    } sdr_err_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
// Command decoder: turns the sampled control pins into one command per clock.
// Assumes: cke low at the previous edge suspends the clock, so the current
// command is discarded; cs_n high deselects the device (no-op).
module sdr_cmd_decode
    import sdr_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdr_cmd_e cmd
);

    logic cke_q;

    // Remember clock enable from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    // Map the strobe pattern onto a command.
    always_comb begin
        if (!cke_q || cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_bank_track.sv
// One bank's tracker: open/closed state, auto-precharge lock and two
// saturating clock counters (since activate, since precharge).
// Assumes: the caller only issues go-pulses that are legal for this bank.
// Counter value at an edge equals the clocks elapsed since the event.
module sdr_bank_track #(
    parameter int TW = 4,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          pre_go,
    input  logic          rwap_go,
    input  logic [AW-1:0] burst_len,
    output logic          is_open,
    output logic          ap_busy,
    output logic [TW-1:0] since_act,
    output logic [TW-1:0] since_pre
);

    localparam logic [TW-1:0] SAT = '1;
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] ap_rem;
    logic          ap_done;

    assign ap_busy = (ap_rem != '0);
    assign ap_done = (rwap_go && burst_len == ONE) || (ap_rem == ONE);

    // Bank open state and auto-precharge countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            ap_rem  <= '0;
        end else begin
            if (act_go)                  is_open <= 1'b1;
            else if (pre_go || ap_done)  is_open <= 1'b0;
            if (rwap_go)                 ap_rem <= burst_len - ONE;
            else if (ap_rem != '0)       ap_rem <= ap_rem - ONE;
        end
    end

    // Elapsed-clock counters for spacing rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_pre <= SAT;
        end else begin
            if (act_go)                 since_act <= TW'(1);
            else if (since_act != SAT)  since_act <= since_act + 1'b1;
            if (pre_go)                 since_pre <= TW'(1);
            else if (ap_done)           since_pre <= '0;
            else if (since_pre != SAT)  since_pre <= since_pre + 1'b1;
        end
    end

endmodule

// File: rtl/sdr_cmd_monitor.sv
// Passive SDRAM command bus checker (top).
// Decodes one command per clock, judges it against per-bank state and
// clock-count spacing limits, and reports one violation code per clock
// (lowest code wins), a sticky flag and a saturating count.
// Assumes: all limits are in clocks; a flagged command has no effect on
// the tracked state; reports are registered (one clock after sampling).
module sdr_cmd_monitor
    import sdr_mon_pkg::*;
#(
    parameter int T_RCD       = 3,
    parameter int T_RP        = 3,
    parameter int T_RAS       = 6,
    parameter int T_RRD       = 2,
    parameter int T_MRD       = 2,
    parameter int BURST_LEN   = 4,
    parameter int PAGE_LEN    = 512,
    parameter bit BL_FROM_MRS = 1'b1,
    parameter int BA_W        = 2,
    parameter int COUNT_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cke,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic [BA_W-1:0]    ba,
    input  logic               ap_flag,
    input  logic [2:0]         mode_key,
    output logic               err_flag,
    output logic               err_valid,
    output logic [3:0]         err_code,
    output logic [COUNT_W-1:0] err_count
);

    localparam int NB    = 1 << BA_W;
    localparam int TMAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMAX2 = (T_RAS > T_RRD) ? T_RAS : T_RRD;
    localparam int TMAX3 = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TMAX  = (TMAX3 > T_MRD) ? TMAX3 : T_MRD;
    localparam int TW    = $clog2(TMAX + 1) + 1;
    localparam int AW    = $clog2(PAGE_LEN + 1);

    localparam logic [TW-1:0] SAT     = '1;
    localparam logic [TW-1:0] RCD_LIM = TW'(T_RCD);
    localparam logic [TW-1:0] RP_LIM  = TW'(T_RP);
    localparam logic [TW-1:0] RAS_LIM = TW'(T_RAS);
    localparam logic [TW-1:0] RRD_LIM = TW'(T_RRD);
    localparam logic [TW-1:0] MRD_LIM = TW'(T_MRD);

    sdr_cmd_e        cmd;
    sdr_err_e        viol;
    logic            is_col, legal;
    logic [NB-1:0]   bank_open, bank_busy, ras_short;
    logic [NB-1:0]   act_go, pre_go, rwap_go;
    logic [TW-1:0]   since_act [NB];
    logic [TW-1:0]   since_pre [NB];
    logic [TW-1:0]   since_mrs, since_any_act;
    logic [BA_W-1:0] last_act_bank;
    logic [AW-1:0]   burst_len, bl_next;

    sdr_cmd_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign legal  = (viol == ERR_NONE) && (cmd != CMD_NOP);

    // One tracker per bank, plus its go-pulses and row-time check.
    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign act_go[g]  = legal && cmd == CMD_ACT && ba == BA_W'(g);
        assign pre_go[g]  = legal && cmd == CMD_PRE && (ap_flag || ba == BA_W'(g))
                            && bank_open[g] && !bank_busy[g];
        assign rwap_go[g] = legal && is_col && ap_flag && ba == BA_W'(g);
        assign ras_short[g] = bank_open[g] && !bank_busy[g] && (since_act[g] < RAS_LIM);

        sdr_bank_track #(.TW(TW), .AW(AW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_go[g]),
            .pre_go    (pre_go[g]),
            .rwap_go   (rwap_go[g]),
            .burst_len (burst_len),
            .is_open   (bank_open[g]),
            .ap_busy   (bank_busy[g]),
            .since_act (since_act[g]),
            .since_pre (since_pre[g])
        );
    end

    // Judge the current command; the first broken rule sets the code.
    always_comb begin
        viol = ERR_NONE;
        if (cmd != CMD_NOP && since_mrs < MRD_LIM)
            viol = ERR_MRS_LOCK;
        else if ((cmd == CMD_MRS || cmd == CMD_REF) && |bank_open)
            viol = ERR_BANKS_OPEN;
        else if (cmd == CMD_ACT && bank_open[ba])
            viol = ERR_ACT_OPEN;
        else if (cmd == CMD_ACT && since_pre[ba] < RP_LIM)
            viol = ERR_T_RP;
        else if (cmd == CMD_ACT && since_any_act < RRD_LIM && last_act_bank != ba)
            viol = ERR_T_RRD;
        else if (is_col && !bank_open[ba])
            viol = ERR_RW_IDLE;
        else if (is_col && bank_busy[ba])
            viol = ERR_AP_LOCK;
        else if (is_col && since_act[ba] < RCD_LIM)
            viol = ERR_T_RCD;
        else if (cmd == CMD_PRE && (ap_flag ? |ras_short : ras_short[ba]))
            viol = ERR_T_RAS;
    end

    // Burst length carried by a mode set.
    always_comb begin
        bl_next = burst_len;
        case (mode_key)
            3'd0:    bl_next = AW'(1);
            3'd1:    bl_next = AW'(2);
            3'd2:    bl_next = AW'(4);
            3'd3:    bl_next = AW'(8);
            3'd7:    bl_next = AW'(PAGE_LEN);
            default: bl_next = burst_len;
        endcase
    end

    // Bus-wide timers, last activated bank and burst length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_mrs     <= SAT;
            since_any_act <= SAT;
            last_act_bank <= '0;
            burst_len     <= AW'(BURST_LEN);
        end else begin
            if (legal && cmd == CMD_MRS)  since_mrs <= TW'(1);
            else if (since_mrs != SAT)    since_mrs <= since_mrs + 1'b1;
            if (legal && cmd == CMD_ACT) begin
                since_any_act <= TW'(1);
                last_act_bank <= ba;
            end else if (since_any_act != SAT) begin
                since_any_act <= since_any_act + 1'b1;
            end
            if (BL_FROM_MRS && legal && cmd == CMD_MRS) burst_len <= bl_next;
        end
    end

    // Registered violation report, sticky flag and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= 4'd0;
            err_flag  <= 1'b0;
            err_count <= '0;
        end else begin
            err_valid <= (viol != ERR_NONE);
            err_code  <= viol;
            if (viol != ERR_NONE) begin
                err_flag <= 1'b1;
                if (err_count != '1) err_count <= err_count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdr_cmd_monitor_sva.sv
// Assertion checker for sdr_cmd_monitor, attached by bind below.
// Assumes: synchronous active-low reset; reports lag the sampled pins by one clock.
module sdr_cmd_monitor_sva #(
    parameter int COUNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cke,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic               err_flag,
    input logic               err_valid,
    input logic [3:0]         err_code,
    input logic [COUNT_W-1:0] err_count
);

    logic [1:0] age;

    // Clocks since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1: a deselected or no-op cycle never produces a report.
    p_nop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && ($past(cs_n) || ($past(ras_n) && $past(cas_n) && $past(we_n))))
        |-> !err_valid);

    // R2: a command after a clock-enable-low edge is not reported.
    p_suspend_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && !$past(cke, 2)) |-> !err_valid);

    // R14: code and valid agree.
    p_code_valid_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid == (err_code != 4'd0));

    // R14: codes stay within the defined set.
    p_code_range_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err_code <= 4'd9);

    // R14: the flag is sticky and covers every report.
    p_flag_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    p_flag_covers_r14: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_flag);

    // R14: the counter moves only with a report.
    p_count_moves_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && err_count != $past(err_count)) |-> err_valid);

endmodule

bind sdr_cmd_monitor sdr_cmd_monitor_sva #(.COUNT_W(COUNT_W)) u_sva (.*);

// File: tb/tb_sdr_cmd_monitor.sv
// Bench for sdr_cmd_monitor: drives one command per clock and compares
// the report outputs every clock with a behavioural timeline model.
module tb_sdr_cmd_monitor;

    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RRD = 2, T_MRD = 2;
    localparam int BL0 = 4, PAGE = 512, CW = 8;

    localparam int K_NOP = 0, K_MRS = 1, K_REF = 2, K_ACT = 3, K_RD = 4,
                   K_WR = 5, K_PRE = 6, K_BST = 7, K_DESEL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic ap_flag = 1'b0;
    logic [2:0] mode_key = 3'd0;
    logic err_flag, err_valid;
    logic [3:0] err_code;
    logic [CW-1:0] err_count;

    always #2 clk = ~clk;

    sdr_cmd_monitor #(
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RRD(T_RRD), .T_MRD(T_MRD),
        .BURST_LEN(BL0), .PAGE_LEN(PAGE), .BL_FROM_MRS(1'b1), .BA_W(2), .COUNT_W(CW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap_flag(ap_flag),
        .mode_key(mode_key), .err_flag(err_flag), .err_valid(err_valid),
        .err_code(err_code), .err_count(err_count)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference timeline
    int cyc = 0;
    int last_act[4], last_pre[4], ap_end[4];
    bit open_b[4], ap_pend[4];
    int last_mrs = -1000, last_any = -1000, last_bk = 0;
    int bl = BL0;
    bit prev_cke = 1;
    int exp_code = 0, exp_count = 0;
    bit exp_flag = 0;

    function automatic int model(input int kind, input int b, input bit a10,
                                 input int key, input bit ck);
        int code;
        bit valid, any_open, short_ras;
        code = 0;
        for (int i = 0; i < 4; i++)
            if (ap_pend[i] && cyc >= ap_end[i]) begin
                open_b[i] = 0; ap_pend[i] = 0; last_pre[i] = ap_end[i];
            end
        valid = prev_cke && kind != K_NOP && kind != K_DESEL;
        any_open = 0;
        short_ras = 0;
        for (int i = 0; i < 4; i++) begin
            if (open_b[i]) any_open = 1;
            if (open_b[i] && !ap_pend[i] && (a10 || i == b) && cyc - last_act[i] < T_RAS)
                short_ras = 1;
        end
        if (valid) begin
            if (cyc - last_mrs < T_MRD) code = 1;
            else if ((kind == K_MRS || kind == K_REF) && any_open) code = 2;
            else if (kind == K_ACT && open_b[b]) code = 3;
            else if (kind == K_ACT && cyc - last_pre[b] < T_RP) code = 4;
            else if (kind == K_ACT && cyc - last_any < T_RRD && last_bk != b) code = 5;
            else if ((kind == K_RD || kind == K_WR) && !open_b[b]) code = 6;
            else if ((kind == K_RD || kind == K_WR) && ap_pend[b]) code = 7;
            else if ((kind == K_RD || kind == K_WR) && cyc - last_act[b] < T_RCD) code = 8;
            else if (kind == K_PRE && short_ras) code = 9;
        end
        if (valid && code == 0) begin
            case (kind)
                K_MRS: begin
                    last_mrs = cyc;
                    case (key)
                        0: bl = 1;
                        1: bl = 2;
                        2: bl = 4;
                        3: bl = 8;
                        7: bl = PAGE;
                        default: bl = bl;
                    endcase
                end
                K_ACT: begin
                    open_b[b] = 1; last_act[b] = cyc; last_any = cyc; last_bk = b;
                end
                K_RD, K_WR: if (a10) begin ap_pend[b] = 1; ap_end[b] = cyc + bl; end
                K_PRE: for (int i = 0; i < 4; i++)
                    if ((a10 || i == b) && open_b[i] && !ap_pend[i]) begin
                        open_b[i] = 0; last_pre[i] = cyc;
                    end
                default: ;
            endcase
        end
        prev_cke = ck;
        cyc++;
        return code;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (err_valid !== (exp_code != 0) || err_code !== 4'(exp_code) ||
            err_flag !== exp_flag || err_count !== CW'(exp_count)) begin
            errors++;
            $display("FAIL %s cyc=%0d: valid=%0b code=%0d flag=%0b count=%0d expected valid=%0b code=%0d flag=%0b count=%0d",
                     tag, cyc - 1, err_valid, err_code, err_flag, err_count,
                     exp_code != 0, exp_code, exp_flag, exp_count);
        end
    endtask

    task automatic step(input int kind, input int b, input bit a10, input int key,
                        input bit ck, input string tag);
        logic [2:0] pins;
        case (kind)
            K_MRS, K_DESEL: pins = 3'b000;
            K_REF: pins = 3'b001;
            K_ACT: pins = 3'b011;
            K_RD:  pins = 3'b101;
            K_WR:  pins = 3'b100;
            K_PRE: pins = 3'b010;
            K_BST: pins = 3'b110;
            default: pins = 3'b111;
        endcase
        cs_n = (kind == K_DESEL);
        {ras_n, cas_n, we_n} = pins;
        ba = 2'(b);
        ap_flag = a10;
        mode_key = 3'(key);
        cke = ck;
        @(posedge clk);
        exp_code = model(kind, b, a10, key, ck);
        if (exp_code != 0) begin
            exp_flag = 1;
            if (exp_count < (1 << CW) - 1) exp_count++;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) step(K_NOP, 0, 0, 0, 1, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -1000; last_pre[i] = -1000; ap_end[i] = 0;
            open_b[i] = 0; ap_pend[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_code = 0;
        check("R14 reset state");

        step(K_MRS, 0, 0, 2, 1, "R12 mode set burst 4");
        step(K_ACT, 0, 0, 0, 1, "R5 activate inside lockout");
        step(K_ACT, 0, 0, 0, 1, "R5 activate at lockout limit");
        step(K_RD,  0, 0, 0, 1, "R7 read one clock after activate");
        step(K_NOP, 0, 0, 0, 1, "R1 no-op");
        step(K_RD,  0, 0, 0, 1, "R7 read at row-to-column limit");
        step(K_RD,  0, 0, 0, 1, "R13 back-to-back read");
        step(K_WR,  0, 0, 0, 1, "R13 back-to-back write");
        step(K_ACT, 2, 0, 0, 1, "R10 activate bank 2");
        step(K_ACT, 3, 0, 0, 1, "R10 activate other bank too soon");
        step(K_ACT, 3, 0, 0, 1, "R10 activate at row-to-row limit");
        step(K_PRE, 3, 0, 0, 1, "R9 precharge before row time");
        step(K_PRE, 1, 1, 0, 1, "R9 precharge-all ignores bank address");
        step(K_ACT, 0, 0, 0, 1, "R6 activate open bank");
        step(K_RD,  1, 0, 0, 1, "R3 read closed bank 01");
        step(K_RD,  2, 0, 0, 1, "R3 read open bank 10");
        step(K_REF, 0, 0, 0, 1, "R4 refresh with open banks");
        step(K_MRS, 0, 0, 0, 1, "R4 mode set with open banks");
        step(K_PRE, 1, 1, 0, 1, "R9 precharge-all after row time");
        step(K_ACT, 0, 0, 0, 1, "R8 activate inside precharge time");
        step(K_NOP, 0, 0, 0, 1, "R1 no-op");
        step(K_ACT, 0, 0, 0, 1, "R8 activate at precharge limit");
        step(K_DESEL, 0, 0, 0, 1, "R1 deselected strobes low");
        step(K_NOP, 0, 0, 0, 0, "R2 clock enable low");
        step(K_ACT, 0, 0, 0, 1, "R2 suspended activate ignored");
        step(K_RD,  0, 1, 0, 1, "R11 read with auto-precharge");
        step(K_RD,  0, 0, 0, 1, "R11 read during auto-precharge burst");
        step(K_NOP, 0, 0, 0, 1, "R11 no-op");
        step(K_WR,  0, 0, 0, 1, "R11 write on last locked clock");
        step(K_RD,  0, 0, 0, 1, "R11 read after burst closes bank");
        step(K_ACT, 0, 0, 0, 1, "R8 activate too soon after auto-precharge");
        step(K_NOP, 0, 0, 0, 1, "R11 no-op");
        step(K_ACT, 0, 0, 0, 1, "R11 activate after auto-precharge");
        nops(5, "R1 idle");
        step(K_PRE, 0, 0, 0, 1, "R9 precharge bank 0");
        nops(2, "R1 idle");
        step(K_MRS, 0, 0, 0, 1, "R12 mode set burst 1");
        step(K_RD,  1, 0, 0, 1, "R14 lockout beats closed-bank code");
        step(K_NOP, 0, 0, 0, 1, "R1 no-op");
        step(K_ACT, 1, 0, 0, 1, "R6 activate bank 1");
        nops(2, "R1 idle");
        step(K_WR,  1, 1, 0, 1, "R12 write auto-precharge burst 1");
        step(K_WR,  1, 0, 0, 1, "R12 bank closed after one clock");
        step(K_BST, 0, 0, 0, 1, "R1 burst stop legal");
        step(K_MRS, 0, 0, 3, 1, "R12 mode set burst 8");
        nops(2, "R1 idle");
        step(K_ACT, 2, 0, 0, 1, "R12 activate bank 2");
        nops(2, "R1 idle");
        step(K_RD,  2, 1, 0, 1, "R12 read auto-precharge burst 8");
        nops(6, "R11 idle");
        step(K_RD,  2, 0, 0, 1, "R12 seventh clock still locked");
        step(K_RD,  2, 0, 0, 1, "R12 bank closed after eight clocks");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule